// File: doc/BRIEF.md
# Generate-Cancel Priority Carry Adder

A pipelined binary adder of parameter width (eight bits by default) that does not ripple its carries. Each operand bit pair is first sorted into one of three classes: it creates a carry (generate), it destroys any carry arriving from below (cancel), or it passes a carry through unchanged. The carry into any bit is then found directly, for all bits at once: look downward from that bit, and the carry is set only when the nearest classified position is a generate. The carry-in sits as an extra classified position below bit 0, and the carry-out is the resolved carry above the top bit.

A mode input turns the block into a bitwise OR unit that reuses the same final sum path. Three register stages (classify, carry resolve, final sum) give a fixed latency, and a new operation can enter on every clock. A build parameter selects how the generate class is formed: from the AND of the operands, from their XNOR (which also flags both-zero positions, where cancel must win), or from the NOR of internally inverted operands.

Top module: `gcp_adder`

## Requirements
- R1: In add mode (`or_mode` = 0) the pair {`cout`, `sum_out`} equals `a_in` + `b_in` + `cin` taken as an unsigned value of W+1 bits.
- R2: In OR mode (`or_mode` = 1) `sum_out` equals `a_in` | `b_in`, `cout` is 0, and `cin` has no effect on either output.
- R3: Outputs for an operation sampled on a rising edge are updated on the third rising edge counting the sampling edge; `valid_out` is `valid_in` delayed by exactly that amount, and operations may enter on consecutive cycles.
- R4: While `rst` (synchronous, active high) is sampled high, the next edge clears `valid_out`, `sum_out` and `cout` to 0 whatever the inputs are.
- R5: The carry into a position is 0 whenever the position directly below it is a cancel (both operand bits 0, or `cin` = 0 for the lowest slot), and 1 whenever that position is a generate that is not also a cancel; a cancel overrides a generate at the same or any lower position.
- R6: The XNOR-generate build gives the same outputs as R1 and R2 for every input, so the cancel at a both-zero position always beats the generate flagged there.
- R7: The inverted-operand build (generate taken as NOR of the complemented operands) gives the same outputs as R1 and R2 for every input.
- R8: A carry-in of 1 travels through any run of propagate positions (operand bits differing) up to and including the carry-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of all pipeline registers |
| a_in | input | W | First operand |
| b_in | input | W | Second operand |
| cin | input | 1 | Carry-in, used in add mode only |
| or_mode | input | 1 | 0 selects addition, 1 selects bitwise OR |
| valid_in | input | 1 | Marks the inputs of this cycle as an operation |
| sum_out | output | W | Sum or OR result |
| cout | output | 1 | Carry-out of the addition, 0 in OR mode |
| valid_out | output | 1 | Marks `sum_out` and `cout` as holding a result |

## Verification
The hardest situation to reach from the ports is a long unbroken propagate run where the only event is at the very bottom, so that the carry-in alone decides every carry up to the carry-out; random operands almost never produce eight differing bit pairs. Directed patterns such as all-ones plus zero with carry-in set, and the carry-in cleared under the same operands, force that case. The tie between generate and cancel in the XNOR build needs positions with both operand bits zero next to carries from below; an exhaustive sweep of a four-bit slice of both operands and the carry-in covers every such local pattern, while random eight-bit traffic with interleaved OR operations and idle gaps checks the streaming latency.

// File: rtl/gcp_pkg.sv
`timescale 1ns/1ps
package gcp_pkg;

  // How the generate class of one bit is formed.
  typedef enum logic [1:0] {
    GEN_AND    = 2'd0,
    GEN_XNOR   = 2'd1,
    GEN_INVNOR = 2'd2
  } gen_style_e;

  // Generate flag of one bit pair; an/bn are the complemented operands.
  function automatic logic gen_bit(gen_style_e style, logic a, logic b,
                                   logic an, logic bn);
    logic g;
    case (style)
      GEN_AND:  g = a & b;
      GEN_XNOR: g = ~(a ^ b);
      default:  g = ~(an | bn);
    endcase
    return g;
  endfunction

  // Cancel flag of one bit pair: neither operand bit is set.
  function automatic logic cancel_bit(logic a, logic b);
    return ~(a | b);
  endfunction

  // A generate only counts as a pure generate when cancel does not also hold.
  function automatic logic pure_gen(logic g, logic c);
    return g & ~c;
  endfunction

endpackage

// File: rtl/gcp_classify.sv
`timescale 1ns/1ps
module gcp_classify #(
  parameter int W = 8,
  parameter gcp_pkg::gen_style_e GEN_STYLE = gcp_pkg::GEN_AND
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  input  logic           or_mode,
  input  logic           vld_in,
  output logic [W-1:0]   psum,
  output logic [W-1:0]   ign,
  output logic [W:0]     gen_x,
  output logic [W:0]     can_x,
  output logic           mode,
  output logic           vld
);
  import gcp_pkg::*;

  localparam int EXT = W + 1;

  logic [W-1:0] a_n;
  logic [W-1:0] b_n;
  logic [EXT-1:0] gen_c;
  logic [EXT-1:0] can_c;
  logic [W-1:0] psum_c;
  logic [W-1:0] ign_c;

  // Front end: both polarities of each operand.
  assign a_n = ~a;
  assign b_n = ~b;

  // Slot 0 of the extended vectors stands for the carry-in.
  assign gen_c[0] = cin;
  assign can_c[0] = ~cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_c[i+1] = gen_bit(GEN_STYLE, a[i], b[i], a_n[i], b_n[i]);
    assign can_c[i+1] = cancel_bit(a[i], b[i]);
    assign psum_c[i]  = a[i] ^ b[i];
    assign ign_c[i]   = pure_gen(gen_c[i+1], can_c[i+1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psum  <= '0;
      ign   <= '0;
      gen_x <= '0;
      can_x <= '0;
      mode  <= 1'b0;
      vld   <= 1'b0;
    end else begin
      psum  <= psum_c;
      ign   <= ign_c;
      gen_x <= gen_c;
      can_x <= can_c;
      mode  <= or_mode;
      vld   <= vld_in;
    end
  end

endmodule

// File: rtl/gcp_resolve.sv
`timescale 1ns/1ps
module gcp_resolve #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W:0]     gen_x,
  input  logic [W:0]     can_x,
  input  logic [W-1:0]   psum_in,
  input  logic [W-1:0]   ign_in,
  input  logic           mode_in,
  input  logic           vld_in,
  output logic [W:0]     carry,
  output logic [W-1:0]   psum,
  output logic [W-1:0]   ign,
  output logic           mode,
  output logic           vld
);

  localparam int EXT = W + 1;

  logic [EXT-1:0] carry_c;

  // For every slot k, the cancels from k downward are ORed into a block
  // mask first; a generate counts only where no cancel sits at or above it
  // (up to k). All slots are evaluated side by side.
  always_comb begin
    for (int k = 0; k < EXT; k++) begin
      logic blk;
      logic acc;
      blk = 1'b0;
      acc = 1'b0;
      for (int p = k; p >= 0; p--) begin
        blk = blk | can_x[p];
        acc = acc | (gen_x[p] & ~blk);
      end
      carry_c[k] = acc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry <= '0;
      psum  <= '0;
      ign   <= '0;
      mode  <= 1'b0;
      vld   <= 1'b0;
    end else begin
      carry <= carry_c;
      psum  <= psum_in;
      ign   <= ign_in;
      mode  <= mode_in;
      vld   <= vld_in;
    end
  end

endmodule

// File: rtl/gcp_finish.sv
`timescale 1ns/1ps
module gcp_finish #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W:0]     carry,
  input  logic [W-1:0]   psum,
  input  logic [W-1:0]   ign,
  input  logic           mode,
  input  logic           vld_in,
  output logic [W-1:0]   result,
  output logic           cout,
  output logic           vld
);

  logic [W-1:0] res_c;
  logic         cout_c;

  // OR mode floods the partial sum with the pure generates; the partial
  // sum is never 1 where the OR is 0, so no masking is needed.
  always_comb begin
    if (mode) begin
      res_c  = psum | ign;
      cout_c = 1'b0;
    end else begin
      res_c  = psum ^ carry[W-1:0];
      cout_c = carry[W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      cout   <= 1'b0;
      vld    <= 1'b0;
    end else begin
      result <= res_c;
      cout   <= cout_c;
      vld    <= vld_in;
    end
  end

endmodule

// File: rtl/gcp_adder.sv
`timescale 1ns/1ps
module gcp_adder #(
  parameter int W = 8,
  parameter gcp_pkg::gen_style_e GEN_STYLE = gcp_pkg::GEN_AND
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  input  logic           cin,
  input  logic           or_mode,
  input  logic           valid_in,
  output logic [W-1:0]   sum_out,
  output logic           cout,
  output logic           valid_out
);

  localparam int EXT = W + 1;

  // Stage-one classification, brought out by name for the checker.
  logic [W-1:0]   s1_psum;
  logic [W-1:0]   s1_ign;
  logic [EXT-1:0] s1_gen;
  logic [EXT-1:0] s1_can;
  logic           s1_mode;
  logic           s1_vld;

  // Stage-two resolved carries.
  logic [EXT-1:0] s2_carry;
  logic [W-1:0]   s2_psum;
  logic [W-1:0]   s2_ign;
  logic           s2_mode;
  logic           s2_vld;

  gcp_classify #(.W(W), .GEN_STYLE(GEN_STYLE)) u_cls (
    .clk    (clk),
    .rst    (rst),
    .a      (a_in),
    .b      (b_in),
    .cin    (cin),
    .or_mode(or_mode),
    .vld_in (valid_in),
    .psum   (s1_psum),
    .ign    (s1_ign),
    .gen_x  (s1_gen),
    .can_x  (s1_can),
    .mode   (s1_mode),
    .vld    (s1_vld)
  );

  gcp_resolve #(.W(W)) u_res (
    .clk    (clk),
    .rst    (rst),
    .gen_x  (s1_gen),
    .can_x  (s1_can),
    .psum_in(s1_psum),
    .ign_in (s1_ign),
    .mode_in(s1_mode),
    .vld_in (s1_vld),
    .carry  (s2_carry),
    .psum   (s2_psum),
    .ign    (s2_ign),
    .mode   (s2_mode),
    .vld    (s2_vld)
  );

  gcp_finish #(.W(W)) u_fin (
    .clk   (clk),
    .rst   (rst),
    .carry (s2_carry),
    .psum  (s2_psum),
    .ign   (s2_ign),
    .mode  (s2_mode),
    .vld_in(s2_vld),
    .result(sum_out),
    .cout  (cout),
    .vld   (valid_out)
  );

endmodule

// File: rtl/gcp_adder_chk.sv
`timescale 1ns/1ps
module gcp_adder_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   a_in,
  input logic [W-1:0]   b_in,
  input logic           cin,
  input logic           or_mode,
  input logic           valid_in,
  input logic [W-1:0]   sum_out,
  input logic           cout,
  input logic           valid_out,
  input logic [W:0]     s1_gen,
  input logic [W:0]     s1_can,
  input logic [W:0]     s2_carry
);

  // Count of edges seen out of reset, saturating at the pipeline depth.
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst)              cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  logic [W:0] arith_now;
  logic [W:0] or_now;
  assign arith_now = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, cin};
  assign or_now    = {1'b0, a_in | b_in};

  // R1
  a_r1_add_result: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && valid_out && !$past(or_mode, 3))
      |-> ({cout, sum_out} == $past(arith_now, 3)));

  // R2
  a_r2_or_result: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && valid_out && $past(or_mode, 3))
      |-> ({cout, sum_out} == $past(or_now, 3)));

  // R3
  a_r3_valid_delay: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) |-> (valid_out == $past(valid_in, 3)));

  // R4
  a_r4_reset_clears: assert property (@(posedge clk)
    rst |=> (!valid_out && sum_out == '0 && !cout));

  // R5: a cancel below a slot forbids its carry
  a_r5_cancel_wins: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0) |-> ((s2_carry & $past(s1_can)) == '0));

  // R5: a pure generate below a slot forces its carry
  a_r5_generate_sets: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0) |-> (($past(s1_gen & ~s1_can) & ~s2_carry) == '0));

endmodule

bind gcp_adder gcp_adder_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_in     (a_in),
  .b_in     (b_in),
  .cin      (cin),
  .or_mode  (or_mode),
  .valid_in (valid_in),
  .sum_out  (sum_out),
  .cout     (cout),
  .valid_out(valid_out),
  .s1_gen   (s1_gen),
  .s1_can   (s1_can),
  .s2_carry (s2_carry)
);

// File: tb/gcp_adder_test.sv
`timescale 1ns/1ps
module gcp_adder_test;
  import gcp_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_in = '0;
  logic [7:0] b_in = '0;
  logic       cin = 1'b0;
  logic       or_mode = 1'b0;
  logic       valid_in = 1'b0;

  logic [7:0] s_and, s_xn, s_inv;
  logic       c_and, c_xn, c_inv;
  logic       v_and, v_xn, v_inv;
  logic [3:0] s4;
  logic       c4, v4;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gcp_adder #(.W(8), .GEN_STYLE(GEN_AND)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cin(cin),
    .or_mode(or_mode), .valid_in(valid_in),
    .sum_out(s_and), .cout(c_and), .valid_out(v_and));

  gcp_adder #(.W(8), .GEN_STYLE(GEN_XNOR)) uut_x (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cin(cin),
    .or_mode(or_mode), .valid_in(valid_in),
    .sum_out(s_xn), .cout(c_xn), .valid_out(v_xn));

  gcp_adder #(.W(8), .GEN_STYLE(GEN_INVNOR)) uut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cin(cin),
    .or_mode(or_mode), .valid_in(valid_in),
    .sum_out(s_inv), .cout(c_inv), .valid_out(v_inv));

  gcp_adder #(.W(4), .GEN_STYLE(GEN_XNOR)) uut4 (
    .clk(clk), .rst(rst), .a_in(a_in[3:0]), .b_in(b_in[3:0]), .cin(cin),
    .or_mode(or_mode), .valid_in(valid_in),
    .sum_out(s4), .cout(c4), .valid_out(v4));

  // Stimulus history: index 0 driven one negedge ago, 2 three ago.
  logic [7:0] h_a [3];
  logic [7:0] h_b [3];
  logic       h_c [3];
  logic       h_m [3];
  logic       h_v [3];
  string      h_t [3];

  function automatic logic [8:0] ref8(logic [7:0] a, logic [7:0] b,
                                      logic c, logic m);
    if (m) return {1'b0, a | b};
    return 9'(int'(a) + int'(b) + int'(c));
  endfunction

  function automatic logic [4:0] ref4(logic [3:0] a, logic [3:0] b,
                                      logic c, logic m);
    if (m) return {1'b0, a | b};
    return 5'(int'(a) + int'(b) + int'(c));
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)",
               tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    chk("R3", "valid_out", {8'h0, v_and}, {8'h0, h_v[2]});
    chk("R3", "valid_out w4", {8'h0, v4}, {8'h0, h_v[2]});
    if (h_v[2]) begin
      chk(h_t[2], "and build", {c_and, s_and},
          ref8(h_a[2], h_b[2], h_c[2], h_m[2]));
      chk("R6", "xnor build", {c_xn, s_xn},
          ref8(h_a[2], h_b[2], h_c[2], h_m[2]));
      chk("R7", "inverted build", {c_inv, s_inv},
          ref8(h_a[2], h_b[2], h_c[2], h_m[2]));
      chk("R6", "xnor w4", {4'h0, c4, s4},
          {4'h0, ref4(h_a[2][3:0], h_b[2][3:0], h_c[2], h_m[2])});
    end
  endtask

  task automatic step(input logic [7:0] a, input logic [7:0] b,
                      input logic c, input logic m, input logic v,
                      input string tag);
    @(negedge clk);
    compare_outputs();
    for (int k = 2; k > 0; k--) begin
      h_a[k] = h_a[k-1]; h_b[k] = h_b[k-1]; h_c[k] = h_c[k-1];
      h_m[k] = h_m[k-1]; h_v[k] = h_v[k-1]; h_t[k] = h_t[k-1];
    end
    h_a[0] = a; h_b[0] = b; h_c[0] = c; h_m[0] = m; h_v[0] = v; h_t[0] = tag;
    a_in = a; b_in = b; cin = c; or_mode = m; valid_in = v;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk, n_fail);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c0a));
    for (int k = 0; k < 3; k++) begin
      h_a[k] = '0; h_b[k] = '0; h_c[k] = 1'b0;
      h_m[k] = 1'b0; h_v[k] = 1'b0; h_t[k] = "R1";
    end

    // R4: reset held with live traffic on the inputs
    repeat (2) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      a_in = 8'($urandom); b_in = 8'($urandom); cin = 1'b1; valid_in = 1'b1;
      @(negedge clk);
      chk("R4", "outputs in reset", {c_and, s_and}, 9'h0);
      chk("R4", "valid in reset", {8'h0, v_and}, 9'h0);
      chk("R4", "w4 in reset", {4'h0, c4, s4}, 9'h0);
    end
    valid_in = 1'b0; a_in = '0; b_in = '0; cin = 1'b0;
    rst = 1'b0;

    // Directed corner cases
    step(8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, "R8");  // carry-in through all bits
    step(8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, "R8");  // same run, cancelled at bottom
    step(8'h7F, 8'h01, 1'b0, 1'b0, 1'b1, "R5");  // generate at bit 0, long run
    step(8'h00, 8'h00, 1'b1, 1'b0, 1'b1, "R5");  // cancel right above carry-in
    step(8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, "R1");
    step(8'h80, 8'h80, 1'b0, 1'b0, 1'b1, "R1");  // carry-out only
    step(8'hAA, 8'h55, 1'b1, 1'b0, 1'b1, "R8");
    step(8'h0F, 8'h01, 1'b0, 1'b0, 1'b1, "R5");  // cancel at bit 4 blocks
    step(8'hF0, 8'h0F, 1'b1, 1'b1, 1'b1, "R2");  // OR, cin ignored
    step(8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, "R2");  // OR, no carry-out
    step(8'h00, 8'h00, 1'b1, 1'b1, 1'b1, "R2");
    step(8'h12, 8'h34, 1'b0, 1'b0, 1'b0, "R3");  // idle gap
    step(8'h01, 8'h01, 1'b1, 1'b0, 1'b1, "R3");
    step(8'h55, 8'h55, 1'b0, 1'b0, 1'b0, "R3");

    // Exhaustive four-bit slice with random upper nibbles
    for (int i = 0; i < 1024; i++) begin
      logic [3:0] lo_a, lo_b;
      lo_a = 4'(i);
      lo_b = 4'(i >> 4);
      step({4'($urandom), lo_a}, {4'($urandom), lo_b}, 1'(i >> 8),
           1'(i >> 9), 1'b1, (i >= 512) ? "R2" : "R1");
    end

    // Random eight-bit traffic with OR operations and gaps
    for (int i = 0; i < 4000; i++) begin
      logic m, v;
      m = (($urandom % 5) == 0);
      v = (($urandom % 8) != 0);
      step(8'($urandom), 8'($urandom), 1'($urandom), m, v, m ? "R2" : "R1");
    end

    // Drain the pipeline
    for (int i = 0; i < 4; i++) step(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R3");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule